// File: doc/BRIEF.md
# Byte ALU with Selective Status Update

This block is the purely combinational arithmetic and logic stage of a small 8-bit RISC core. It takes a first operand, a second operand, a 5-bit operation code and the current status byte. It returns the result byte and the next status byte. The second operand may come from a register or from an immediate field; the block does not care which. The decode stage drives the operation code, and the writeback stage stores both outputs. For compares, writeback discards the result byte and keeps only the status byte.

Every operation writes only its own set of status bits and passes all other bits through unchanged. This lets software chain multi-byte arithmetic and compares through the carry and zero bits. Internally an operation is routed to one of four sources: the add/subtract unit, the bitwise/shift unit, the single-flag unit, or a pass-through path for unused codes.

Top module: `alu8_core`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBC=3, CP=4, CPC=5, NEG=6, AND=7, OR=8, XOR=9, COM=10, INC=11, DEC=12, LSL=13, LSR=14, ASR=15, ROL=16, ROR=17, SWAP=18, FSET=19, FCLR=20. ADC and SBC add or subtract the incoming carry bit as well as the second operand. With all inputs zero, the ADD code gives result 0x00 and status 0x02.
- R2: The status byte holds, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. The ADD, ADC, SUB, SBC, CP, CPC and NEG codes write H, S, V, N, Z and C. Their meanings are: H is the carry out of bit 3 (on subtracts, the borrow into bit 3); V is signed overflow; N is the result's top bit; C is the carry or borrow out of bit 7; S equals N xor V.
- R3: For SBC and CPC, Z becomes 1 only if the result is zero and the incoming Z was 1. Otherwise Z is 0.
- R4: CP and CPC produce the same result byte and flags as SUB and SBC.
- R5: NEG returns 0x00 minus the operand, with flags set as for a subtraction from zero.
- R6: AND, OR and XOR write S, V, N and Z, with V forced to 0. C and H are kept.
- R7: INC and DEC add or subtract 1. They write S, V, N and Z. V is 1 exactly when INC sees 0x7F or DEC sees 0x80. C and H are kept.
- R8: COM returns 0xFF minus the operand. It sets C to 1 and V to 0, and also writes S, N and Z.
- R9: LSL, LSR and ASR shift by one bit. The bit shifted out goes to C. LSL fills bit 0 with 0, LSR fills bit 7 with 0, and ASR keeps bit 7. V becomes N xor C; S, N and Z are also written.
- R10: ROL and ROR rotate through carry: the old C fills the vacated bit and the bit shifted out becomes the new C. Flags are written as in R9.
- R11: SWAP exchanges the two nibbles and leaves the status byte unchanged.
- R12: FSET and FCLR set or clear the one status bit whose position (7=I down to 0=C) is given by the second operand's bits 2..0. They return the first operand as the result.
- R13: I and T change only through FSET and FCLR.
- R14: Codes 21 to 31 return the first operand and leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | DATA_W | First operand (destination register value) |
| b_i | input | DATA_W | Second operand (register or immediate) |
| sreg_i | input | 8 | Current status byte |
| res_o | output | DATA_W | Result byte |
| sreg_o | output | 8 | Next status byte |

## Verification
The bench builds the block at its default width of 8 bits. At that width every first-operand value can be driven for every operation code, combined with second operands at the signed and unsigned wrap points (0x00, 0x01, 0x0F, 0x7F, 0x80, 0xFF) and with all-clear and all-set status bytes. This covers the overflow edges at 0x7F and 0x80, the nibble boundary behind H, carry chaining into ADC, SBC and CPC, and zero chaining for SBC and CPC. Hand-worked vectors separately pin down each flag rule for the single-flag, swap and unused-code paths.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int SREG_W = 8;

    // status bit positions
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    // which status bits each operation class writes
    localparam logic [SREG_W-1:0] MSK_ARITH = 8'h3F; // H S V N Z C
    localparam logic [SREG_W-1:0] MSK_LOGIC = 8'h1E; // S V N Z
    localparam logic [SREG_W-1:0] MSK_SHIFT = 8'h1F; // S V N Z C

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_NEG  = 5'd6,
        OP_AND  = 5'd7,
        OP_OR   = 5'd8,
        OP_XOR  = 5'd9,
        OP_COM  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_ROL  = 5'd16,
        OP_ROR  = 5'd17,
        OP_SWAP = 5'd18,
        OP_FSET = 5'd19,
        OP_FCLR = 5'd20
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_ARITH = 2'd0,
        SRC_BITS  = 2'd1,
        SRC_FLAG  = 2'd2,
        SRC_PASS  = 2'd3
    } alu_src_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              cin_i,
    input  logic              sub_i,
    input  logic              chain_i,
    input  logic              z_prev_i,
    output logic [DATA_W-1:0] res_o,
    output logic              h_o,
    output logic              s_o,
    output logic              v_o,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o
);
    localparam int MSB = DATA_W - 1;
    localparam int HB  = 3;

    logic [DATA_W:0] wide;

    always_comb begin
        if (sub_i)
            wide = {1'b0, x_i} - {1'b0, y_i} - {{DATA_W{1'b0}}, cin_i};
        else
            wide = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i};
        res_o = wide[MSB:0];
        c_o   = wide[DATA_W];
        if (sub_i) begin
            h_o = (~x_i[HB] & y_i[HB]) | (y_i[HB] & res_o[HB]) | (res_o[HB] & ~x_i[HB]);
            v_o = (x_i[MSB] & ~y_i[MSB] & ~res_o[MSB]) | (~x_i[MSB] & y_i[MSB] & res_o[MSB]);
        end else begin
            h_o = (x_i[HB] & y_i[HB]) | (y_i[HB] & ~res_o[HB]) | (~res_o[HB] & x_i[HB]);
            v_o = (x_i[MSB] & y_i[MSB] & ~res_o[MSB]) | (~x_i[MSB] & ~y_i[MSB] & res_o[MSB]);
        end
        n_o = res_o[MSB];
        z_o = (res_o == '0) & (~chain_i | z_prev_i);
        s_o = n_o ^ v_o;
    end

    always_comb begin
        if (chain_i && !z_prev_i)
            a_r3_chain_zero_stays_clear: assert (!z_o)
                else $error("R3: chained zero set without prior zero");
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              s_o,
    output logic              v_o,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o
);
    localparam int MSB  = DATA_W - 1;
    localparam int HALF = DATA_W / 2;
    localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {MSB{1'b1}}};
    localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {MSB{1'b0}}};

    logic is_shift;

    always_comb begin
        res_o    = a_i;
        c_o      = cin_i;
        v_o      = 1'b0;
        is_shift = 1'b0;
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM: begin
                res_o = ~a_i;
                c_o   = 1'b1;
            end
            OP_INC: begin
                res_o = a_i + 1'b1;
                v_o   = (a_i == POS_MAX);
            end
            OP_DEC: begin
                res_o = a_i - 1'b1;
                v_o   = (a_i == NEG_MIN);
            end
            OP_LSL: begin
                res_o    = {a_i[MSB-1:0], 1'b0};
                c_o      = a_i[MSB];
                is_shift = 1'b1;
            end
            OP_LSR: begin
                res_o    = {1'b0, a_i[MSB:1]};
                c_o      = a_i[0];
                is_shift = 1'b1;
            end
            OP_ASR: begin
                res_o    = {a_i[MSB], a_i[MSB:1]};
                c_o      = a_i[0];
                is_shift = 1'b1;
            end
            OP_ROL: begin
                res_o    = {a_i[MSB-1:0], cin_i};
                c_o      = a_i[MSB];
                is_shift = 1'b1;
            end
            OP_ROR: begin
                res_o    = {cin_i, a_i[MSB:1]};
                c_o      = a_i[0];
                is_shift = 1'b1;
            end
            OP_SWAP: res_o = {a_i[HALF-1:0], a_i[MSB:HALF]};
            default: ;
        endcase
        n_o = res_o[MSB];
        z_o = (res_o == '0);
        if (is_shift)
            v_o = n_o ^ c_o;
        s_o = n_o ^ v_o;
    end

    always_comb begin
        if (op_i == OP_LSR)
            a_r9_lsr_top_clear: assert (!n_o)
                else $error("R9: logical right shift left top bit set");
    end

endmodule

// File: rtl/alu8_flagset.sv
module alu8_flagset
    import alu8_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [2:0]        idx_i,
    input  logic [SREG_W-1:0] sreg_i,
    output logic [SREG_W-1:0] sreg_o
);
    always_comb begin
        sreg_o = sreg_i;
        if (op_i == OP_FSET)
            sreg_o[idx_i] = 1'b1;
        else if (op_i == OP_FCLR)
            sreg_o[idx_i] = 1'b0;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [4:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [7:0]        sreg_i,
    output logic [DATA_W-1:0] res_o,
    output logic [7:0]        sreg_o
);
    alu_op_e  op;
    alu_src_e src;
    logic [SREG_W-1:0] mask;
    logic sub, use_c, chain, neg;

    logic [DATA_W-1:0] x_in, y_in, ar_res, bt_res;
    logic ar_h, ar_s, ar_v, ar_n, ar_z, ar_c;
    logic bt_s, bt_v, bt_n, bt_z, bt_c;
    logic [SREG_W-1:0] ar_flags, bt_flags, fs_sreg;

    assign op = alu_op_e'(op_i);

    // decode: source path and written-flag mask
    always_comb begin
        src   = SRC_PASS;
        mask  = '0;
        sub   = 1'b0;
        use_c = 1'b0;
        chain = 1'b0;
        neg   = 1'b0;
        unique case (op)
            OP_ADD: begin src = SRC_ARITH; mask = MSK_ARITH; end
            OP_ADC: begin src = SRC_ARITH; mask = MSK_ARITH; use_c = 1'b1; end
            OP_SUB, OP_CP: begin
                src = SRC_ARITH; mask = MSK_ARITH; sub = 1'b1;
            end
            OP_SBC, OP_CPC: begin
                src = SRC_ARITH; mask = MSK_ARITH; sub = 1'b1;
                use_c = 1'b1; chain = 1'b1;
            end
            OP_NEG: begin
                src = SRC_ARITH; mask = MSK_ARITH; sub = 1'b1; neg = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
                src = SRC_BITS; mask = MSK_LOGIC;
            end
            OP_COM, OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
                src = SRC_BITS; mask = MSK_SHIFT;
            end
            OP_SWAP: begin src = SRC_BITS; mask = '0; end
            OP_FSET, OP_FCLR: src = SRC_FLAG;
            default: src = SRC_PASS;
        endcase
    end

    assign x_in = neg ? '0 : a_i;
    assign y_in = neg ? a_i : b_i;

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .x_i      (x_in),
        .y_i      (y_in),
        .cin_i    (use_c & sreg_i[FL_C]),
        .sub_i    (sub),
        .chain_i  (chain),
        .z_prev_i (sreg_i[FL_Z]),
        .res_o    (ar_res),
        .h_o      (ar_h),
        .s_o      (ar_s),
        .v_o      (ar_v),
        .n_o      (ar_n),
        .z_o      (ar_z),
        .c_o      (ar_c)
    );

    alu8_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (sreg_i[FL_C]),
        .res_o (bt_res),
        .s_o   (bt_s),
        .v_o   (bt_v),
        .n_o   (bt_n),
        .z_o   (bt_z),
        .c_o   (bt_c)
    );

    alu8_flagset u_flagset (
        .op_i   (op),
        .idx_i  (b_i[2:0]),
        .sreg_i (sreg_i),
        .sreg_o (fs_sreg)
    );

    assign ar_flags = {2'b00, ar_h, ar_s, ar_v, ar_n, ar_z, ar_c};
    assign bt_flags = {3'b000, bt_s, bt_v, bt_n, bt_z, bt_c};

    // output select and flag merge
    always_comb begin
        unique case (src)
            SRC_ARITH: begin
                res_o  = ar_res;
                sreg_o = (sreg_i & ~mask) | (ar_flags & mask);
            end
            SRC_BITS: begin
                res_o  = bt_res;
                sreg_o = (sreg_i & ~mask) | (bt_flags & mask);
            end
            SRC_FLAG: begin
                res_o  = a_i;
                sreg_o = fs_sreg;
            end
            default: begin
                res_o  = a_i;
                sreg_o = sreg_i;
            end
        endcase
    end

    always_comb begin
        if (op_i != OP_FSET && op_i != OP_FCLR)
            a_r13_it_bits_kept: assert (sreg_o[7:6] == sreg_i[7:6])
                else $error("R13: I or T changed");
        if (op_i == OP_SWAP)
            a_r11_swap_flags_quiet: assert (sreg_o == sreg_i)
                else $error("R11: swap touched status");
        if (op_i == OP_INC || op_i == OP_DEC)
            a_r7_incdec_keep_c_h: assert (sreg_o[FL_C] == sreg_i[FL_C] && sreg_o[FL_H] == sreg_i[FL_H])
                else $error("R7: inc/dec touched C or H");
        if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
            a_r6_logic_clears_v: assert (!sreg_o[FL_V] && sreg_o[FL_C] == sreg_i[FL_C])
                else $error("R6: logic op V or C wrong");
        if ((src == SRC_ARITH || src == SRC_BITS) && op_i != OP_SWAP)
            a_r2_sign_is_n_xor_v: assert (sreg_o[FL_S] == (sreg_o[FL_N] ^ sreg_o[FL_V]))
                else $error("R2: S differs from N xor V");
        if (op_i == OP_FSET || op_i == OP_FCLR)
            a_r12_single_bit_change: assert ($countones(sreg_o ^ sreg_i) <= 1 && res_o == a_i)
                else $error("R12: flag op changed more than one bit");
        if (op_i > 5'd20)
            a_r14_unused_pass: assert (res_o == a_i && sreg_o == sreg_i)
                else $error("R14: unused code altered outputs");
    end

endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
    import alu8_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op;
    logic [7:0] a, b, s;
    logic [7:0] res, sreg;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu8_core u_alu8_core (
        .op_i   (op),
        .a_i    (a),
        .b_i    (b),
        .sreg_i (s),
        .res_o  (res),
        .sreg_o (sreg)
    );

    function automatic int sgn(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // independent model: returns {result, status}
    function automatic logic [15:0] model(logic [4:0] o, logic [7:0] x8, logic [7:0] y8, logic [7:0] st);
        logic [7:0] r = x8;
        logic [7:0] ns = st;
        int x, y, ci, w, hw, sw;
        bit ov, cy, hc, zz;
        if (o <= 5'd6) begin
            x  = (o == 5'd6) ? 0 : int'(x8);
            y  = (o == 5'd6) ? int'(x8) : int'(y8);
            ci = (o == 5'd1 || o == 5'd3 || o == 5'd5) ? int'(st[0]) : 0;
            if (o <= 5'd1) begin
                w  = x + y + ci;
                hw = (x % 16) + (y % 16) + ci;
                sw = sgn(x) + sgn(y) + ci;
                cy = (w > 255);
                hc = (hw > 15);
            end else begin
                w  = x - y - ci;
                hw = (x % 16) - (y % 16) - ci;
                sw = sgn(x) - sgn(y) - ci;
                cy = (w < 0);
                hc = (hw < 0);
            end
            r  = 8'((w + 512) % 256);
            ov = (sw > 127) || (sw < -128);
            zz = (r == 8'h00);
            if (o == 5'd3 || o == 5'd5) zz = zz && st[1];
            ns[5] = hc; ns[3] = ov; ns[2] = r[7]; ns[4] = r[7] ^ ov;
            ns[1] = zz; ns[0] = cy;
        end else if (o <= 5'd17) begin
            cy = st[0];
            ov = 1'b0;
            case (o)
                5'd7:  r = x8 & y8;
                5'd8:  r = x8 | y8;
                5'd9:  r = x8 ^ y8;
                5'd10: begin r = 8'(255 - int'(x8)); cy = 1'b1; end
                5'd11: begin r = 8'((int'(x8) + 1) % 256); ov = (x8 == 8'h7F); end
                5'd12: begin r = 8'((int'(x8) + 255) % 256); ov = (x8 == 8'h80); end
                5'd13: begin r = 8'((int'(x8) * 2) % 256); cy = x8[7]; end
                5'd14: begin r = 8'(int'(x8) / 2); cy = x8[0]; end
                5'd15: begin r = 8'(int'(x8) / 2) | (x8 & 8'h80); cy = x8[0]; end
                5'd16: begin r = 8'((int'(x8) * 2) % 256) | {7'd0, st[0]}; cy = x8[7]; end
                default: begin r = 8'(int'(x8) / 2) | {st[0], 7'd0}; cy = x8[0]; end
            endcase
            if (o >= 5'd13) ov = r[7] ^ cy;
            ns[3] = ov; ns[2] = r[7]; ns[4] = r[7] ^ ov; ns[1] = (r == 8'h00);
            if (o >= 5'd10) ns[0] = cy;
        end else if (o == 5'd18) begin
            r = {x8[3:0], x8[7:4]};
        end else if (o == 5'd19) begin
            ns[y8[2:0]] = 1'b1;
        end else if (o == 5'd20) begin
            ns[y8[2:0]] = 1'b0;
        end
        return {r, ns};
    endfunction

    function automatic string tag_of(logic [4:0] o);
        if (o <= 5'd3) return "R2";
        if (o <= 5'd5) return "R4";
        if (o == 5'd6) return "R5";
        if (o <= 5'd9) return "R6";
        if (o == 5'd10) return "R8";
        if (o <= 5'd12) return "R7";
        if (o <= 5'd15) return "R9";
        if (o <= 5'd17) return "R10";
        if (o == 5'd18) return "R11";
        if (o <= 5'd20) return "R12";
        return "R14";
    endfunction

    task automatic apply(logic [4:0] o, logic [7:0] x8, logic [7:0] y8, logic [7:0] st);
        @(posedge clk);
        #1;
        op = o; a = x8; b = y8; s = st;
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [7:0] er, logic [7:0] es);
        checks++;
        if (res !== er || sreg !== es) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h s=%02h: got res=%02h sreg=%02h, expected res=%02h sreg=%02h",
                     tag, op, a, b, s, res, sreg, er, es);
        end
    endtask

    task automatic vec(string tag, logic [4:0] o, logic [7:0] x8, logic [7:0] y8,
                       logic [7:0] st, logic [7:0] er, logic [7:0] es);
        apply(o, x8, y8, st);
        check(tag, er, es);
    endtask

    task automatic t_quiescent();
        vec("R1", OP_ADD, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02);
    endtask

    task automatic t_add_sub_corners();
        vec("R2", OP_ADD, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h2C);
        vec("R2", OP_ADD, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h23);
        vec("R1", OP_ADC, 8'h0F, 8'h00, 8'h01, 8'h10, 8'h20);
        vec("R2", OP_SUB, 8'h00, 8'h01, 8'h00, 8'hFF, 8'h35);
        vec("R13", OP_SUB, 8'h00, 8'h01, 8'hC0, 8'hFF, 8'hF5);
    endtask

    task automatic t_zero_chain();
        vec("R3", OP_SBC, 8'h05, 8'h05, 8'h02, 8'h00, 8'h02);
        vec("R3", OP_SBC, 8'h05, 8'h05, 8'h00, 8'h00, 8'h00);
        vec("R3", OP_SBC, 8'h05, 8'h04, 8'h03, 8'h00, 8'h02);
        vec("R4", OP_CPC, 8'h10, 8'h10, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_unary_corners();
        vec("R5", OP_NEG, 8'h80, 8'h00, 8'h00, 8'h80, 8'h0D);
        vec("R10", OP_ROR, 8'h01, 8'h00, 8'h01, 8'h80, 8'h15);
        vec("R10", OP_ROL, 8'h80, 8'h00, 8'h00, 8'h00, 8'h1B);
        vec("R7", OP_INC, 8'h7F, 8'h00, 8'h21, 8'h80, 8'h2D);
        vec("R7", OP_DEC, 8'h80, 8'h00, 8'h00, 8'h7F, 8'h18);
        vec("R8", OP_COM, 8'h55, 8'h00, 8'h00, 8'hAA, 8'h15);
        vec("R11", OP_SWAP, 8'hA5, 8'h00, 8'hC3, 8'h5A, 8'hC3);
        vec("R9", OP_ASR, 8'h81, 8'h00, 8'h00, 8'hC0, 8'h15);
    endtask

    task automatic t_flag_ops();
        vec("R12", OP_FSET, 8'h3C, 8'h07, 8'h00, 8'h3C, 8'h80);
        vec("R12", OP_FCLR, 8'h3C, 8'h00, 8'hFF, 8'h3C, 8'hFE);
        for (int i = 0; i < 8; i++) begin
            vec("R12", OP_FSET, 8'h11, 8'(i), 8'h00, 8'h11, 8'(1 << i));
            vec("R12", OP_FCLR, 8'h11, 8'(i + 8), 8'hFF, 8'h11, ~8'(1 << i));
        end
    endtask

    task automatic t_unused_codes();
        for (int o = 21; o < 32; o++)
            vec("R14", 5'(o), 8'h9E, 8'h01, 8'h5A, 8'h9E, 8'h5A);
    endtask

    task automatic t_sweep(logic [4:0] o);
        logic [7:0] bl [6] = '{8'h00, 8'h01, 8'h0F, 8'h7F, 8'h80, 8'hFF};
        logic [15:0] m;
        for (int x = 0; x < 256; x++)
            for (int j = 0; j < 6; j++)
                for (int k = 0; k < 2; k++) begin
                    apply(o, 8'(x), bl[j], k ? 8'hFF : 8'h00);
                    m = model(o, 8'(x), bl[j], k ? 8'hFF : 8'h00);
                    check(tag_of(o), m[15:8], m[7:0]);
                end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        op = 5'd0; a = 8'h00; b = 8'h00; s = 8'h00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_quiescent();
        t_add_sub_corners();
        t_zero_chain();
        t_unary_corners();
        t_flag_ops();
        t_unused_codes();
        for (int o = 0; o <= 18; o++)
            t_sweep(5'(o));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule